// File: doc/BRIEF.md
# Static Memory Bus Controller

This block turns single read or write requests from an on-chip master into cycles on an external asynchronous memory bus. It has a 24-bit address, a 16-bit data path with separate in, out and enable lines, one active-low select for each of eight regions, and two sets of byte-lane strobes. The master holds `reqValid` high with the address, write data, byte enables and direction stable. A one-cycle `reqReady` pulse ends the request and carries the read data or an error flag.

Each region has its own static configuration word on `cfgFlat`. A word is 18 bits wide and region i occupies bits [18*i+17 : 18*i]. From its LSB upward the word holds: enable (1 bit), base (8 bits, compared against address bits 23:16), size exponent k (3 bits, region spans 64 KB << k, base aligned to that size), wide (1 bit, 1 = 16-bit device, 0 = 8-bit device), wait-state count (3 bits), style (1 bit, 1 = byte-select strobes, 0 = byte-write strobes) and early read (1 bit). A 16-bit request to an 8-bit region becomes two byte cycles.

Timing is counted in controller clocks. One controller clock stands for one half-period slot of the external bus clock, so falling-edge and rising-edge events of the bus map onto consecutive clocks. A bus access has a setup slot with address and select valid, a strobe phase, an optional hold slot, and then a done slot that pulses `reqReady`.

Top module: `ebc_top`

## Requirements
- R1: A request whose address bits 23:16 match an enabled region's base, with the low k bits of the comparison ignored, drives that region's `busCsN` bit low for the whole access. No other select goes low. When regions overlap, the lowest-numbered one wins.
- R2: A request that matches no enabled region starts no bus activity. `reqReady` and `reqErr` both pulse in the clock right after the request is seen.
- R3: In byte-write style (style = 0), writes pulse `busWrLoN` for lane 0 (D7:0) and `busWrHiN` for lane 1 (D15:8), and reads pulse `busRdN`. `busWeN`, `busOeN`, `busUbN` and `busLbN` stay high.
- R4: In byte-select style (style = 1), writes pulse `busWeN` and reads pulse `busOeN`. `busLbN` and `busUbN` mark the active lanes (lane 0 and lane 1) while either strobe is active. `busRdN`, `busWrLoN` and `busWrHiN` stay high.
- R5: With wait-state count W and `busWaitN` high, the write strobe, and the read strobe in standard mode, stays active for exactly 1+W clocks.
- R6: `busWaitN` is sampled on each strobe clock. If it is low on the first K strobe clocks, the strobe lasts max(1+W, K+1) clocks.
- R7: For writes with W > 0, address, select and driven data stay valid for one clock after the write strobe is released. With W = 0 the access ends with the strobe.
- R8: With early read set, the read strobe also covers the setup clock, so it is active in the first select-low clock. In standard mode it starts one clock later.
- R9: On an 8-bit region, a request with both byte enables set makes two byte cycles. The first uses bus address bit 0 = 0 and lane-0 data, the second uses bit 0 = 1 and lane-1 data, both on D7:0. A single `reqReady` pulse follows the second cycle.
- R10: Read data is captured on the last strobe clock. A 16-bit region returns the full bus word. An 8-bit region places the byte from each enabled lane in its lane of `reqRdata`, and bytes of lanes not read are zero.
- R11: `reqReady` is a one-clock pulse. A mapped request completes after (setup + strobe + hold) clocks per byte cycle plus one done clock.
- R12: After reset, all selects and strobes are inactive, `busDoe` is low and `reqReady` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock, one bus half-period per clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgFlat | input | 18*NUM_CS | Static per-region configuration words |
| reqValid | input | 1 | Request present, held until reqReady |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte address, even for 16-bit access |
| reqWdata | input | 16 | Write data |
| reqBe | input | 2 | Byte enables, nonzero |
| reqReady | output | 1 | Completion pulse |
| reqErr | output | 1 | Unmapped address, valid with reqReady |
| reqRdata | output | 16 | Read data, valid with reqReady |
| busAddr | output | ADDR_W | External address |
| busDout | output | 16 | External write data |
| busDoe | output | 1 | Data output enable |
| busDin | input | 16 | External read data |
| busCsN | output | NUM_CS | Active-low region selects |
| busRdN | output | 1 | Read strobe, byte-write style |
| busWrLoN | output | 1 | Lane 0 write strobe, byte-write style |
| busWrHiN | output | 1 | Lane 1 write strobe, byte-write style |
| busWeN | output | 1 | Write enable, byte-select style |
| busOeN | output | 1 | Output enable, byte-select style |
| busUbN | output | 1 | Upper lane select, byte-select style |
| busLbN | output | 1 | Lower lane select, byte-select style |
| busWaitN | input | 1 | Active-low strobe extension |

## Verification
The bench sweeps direction, device width, strobe style, wait count, byte enables and read mode on one region. For each access it counts the select-low clocks, the strobe clocks and the total latency against the formula.

Several faults show up in those counts. A controller that dropped the hold slot, or added it with zero wait states, gives a wrong select count. One that ignored the early-read bit shifts where the read strobe first appears. One that sampled `busWaitN` in the wrong phase returns a short or long strobe.

Split byte cycles are checked for low-lane-first order and for data on D7:0. A wrong lane order puts bytes in swapped places in `reqRdata` or on `busDout`. Overlapping regions and an unmapped address catch wrong decode priority and any bus activity on an error.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  localparam int CFG_W = 18;

  typedef struct packed {
    logic       earlyRd;
    logic       byteSel;
    logic [2:0] waitStates;
    logic       wide;
    logic [2:0] sizeLog;
    logic [7:0] base;
    logic       enable;
  } csCfg_t;

  typedef struct packed {
    logic loadReq;
    logic lane;
    logic driveCs;
    logic driveData;
    logic rdStrobe;
    logic wrStrobe;
    logic capture;
  } busCtl_t;
endpackage

// File: rtl/ebc_decode.sv
module ebc_decode
  import ebc_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int IDX_W  = 3
) (
  input  logic [CFG_W*NUM_CS-1:0] cfgFlat,
  input  logic [7:0]              addrTop,
  output logic                    hit,
  output logic [IDX_W-1:0]        hitIdx,
  output logic                    cfgWide,
  output logic                    cfgSel,
  output logic                    cfgEarly,
  output logic [2:0]              cfgWs
);
  csCfg_t cfgArr [NUM_CS];
  logic [NUM_CS-1:0] match;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_region
    assign cfgArr[i] = csCfg_t'(cfgFlat[i*CFG_W +: CFG_W]);
    assign match[i]  = cfgArr[i].enable &&
                       (((addrTop ^ cfgArr[i].base) >> cfgArr[i].sizeLog) == 8'd0);
  end

  // lowest index wins: scan downward so the last assignment is the smallest hit
  always_comb begin
    hit = 1'b0; hitIdx = '0; cfgWide = 1'b0; cfgSel = 1'b0; cfgEarly = 1'b0; cfgWs = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit      = 1'b1;
        hitIdx   = IDX_W'(i);
        cfgWide  = cfgArr[i].wide;
        cfgSel   = cfgArr[i].byteSel;
        cfgEarly = cfgArr[i].earlyRd;
        cfgWs    = cfgArr[i].waitStates;
      end
    end
  end
endmodule

// File: rtl/ebc_ctrl.sv
module ebc_ctrl
  import ebc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic [1:0] reqBe,
  input  logic       hit,
  input  logic       cfgWide,
  input  logic       cfgEarly,
  input  logic [2:0] cfgWs,
  input  logic       busWaitN,
  output busCtl_t    ctl,
  output logic       reqReady,
  output logic       reqErr
);
  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_STROBE, S_HOLD, S_DONE} state_t;

  state_t     state;
  logic [2:0] cnt, ws;
  logic       early, isWrite, lane, secondPending, errFlag;
  logic       exitOk, onBus;

  assign exitOk = (state == S_STROBE) && (cnt >= ws) && busWaitN;
  assign onBus  = (state == S_SETUP) || (state == S_STROBE) || (state == S_HOLD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; cnt <= '0; ws <= '0; early <= 1'b0; isWrite <= 1'b0;
      lane <= 1'b0; secondPending <= 1'b0; errFlag <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (reqValid) begin
          if (!hit) begin
            errFlag <= 1'b1;
            state   <= S_DONE;
          end else begin
            isWrite       <= reqWrite;
            ws            <= cfgWs;
            early         <= cfgEarly;
            lane          <= cfgWide ? 1'b0 : !reqBe[0];
            secondPending <= !cfgWide && (reqBe == 2'b11);
            cnt           <= '0;
            state         <= S_SETUP;
          end
        end
        S_SETUP: begin
          cnt   <= '0;
          state <= S_STROBE;
        end
        S_STROBE: begin
          if (!exitOk) begin
            if (cnt != 3'd7) cnt <= cnt + 3'd1;
          end else if (isWrite && ws != 3'd0) begin
            state <= S_HOLD;
          end else if (secondPending) begin
            lane <= 1'b1; secondPending <= 1'b0; state <= S_SETUP;
          end else begin
            state <= S_DONE;
          end
        end
        S_HOLD: begin
          if (secondPending) begin
            lane <= 1'b1; secondPending <= 1'b0; state <= S_SETUP;
          end else begin
            state <= S_DONE;
          end
        end
        default: begin
          errFlag <= 1'b0;
          state   <= S_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    ctl.loadReq   = (state == S_IDLE) && reqValid && hit;
    ctl.lane      = lane;
    ctl.driveCs   = onBus;
    ctl.driveData = onBus && isWrite;
    ctl.rdStrobe  = !isWrite && ((state == S_STROBE) || ((state == S_SETUP) && early));
    ctl.wrStrobe  = isWrite && (state == S_STROBE);
    ctl.capture   = !isWrite && exitOk;
  end

  assign reqReady = (state == S_DONE);
  assign reqErr   = (state == S_DONE) && errFlag;
endmodule

// File: rtl/ebc_datapath.sv
module ebc_datapath
  import ebc_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int ADDR_W = 24,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  busCtl_t           ctl,
  input  logic [ADDR_W-1:1] reqAddrHi,
  input  logic [15:0]       reqWdata,
  input  logic [1:0]        reqBe,
  input  logic [IDX_W-1:0]  hitIdx,
  input  logic              cfgWide,
  input  logic              cfgSel,
  input  logic [15:0]       busDin,
  output logic [ADDR_W-1:0] busAddr,
  output logic [15:0]       busDout,
  output logic              busDoe,
  output logic [NUM_CS-1:0] busCsN,
  output logic              busRdN,
  output logic              busWrLoN,
  output logic              busWrHiN,
  output logic              busWeN,
  output logic              busOeN,
  output logic              busUbN,
  output logic              busLbN,
  output logic [15:0]       rdata
);
  logic [ADDR_W-1:1] addrReg;
  logic [15:0]       wdataReg, rdataReg;
  logic [1:0]        beReg, laneMask;
  logic [IDX_W-1:0]  csIdxReg;
  logic              wideReg, selReg, anyStb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0; wdataReg <= '0; rdataReg <= '0; beReg <= '0;
      csIdxReg <= '0; wideReg <= 1'b0; selReg <= 1'b0;
    end else begin
      if (ctl.loadReq) begin
        addrReg  <= reqAddrHi;
        wdataReg <= reqWdata;
        beReg    <= reqBe;
        csIdxReg <= hitIdx;
        wideReg  <= cfgWide;
        selReg   <= cfgSel;
        rdataReg <= '0;
      end
      if (ctl.capture) begin
        if (wideReg)       rdataReg        <= busDin;
        else if (ctl.lane) rdataReg[15:8]  <= busDin[7:0];
        else               rdataReg[7:0]   <= busDin[7:0];
      end
    end
  end

  assign laneMask = wideReg ? beReg : 2'b01;
  assign anyStb   = ctl.rdStrobe || ctl.wrStrobe;
  assign busAddr  = {addrReg, wideReg ? 1'b0 : ctl.lane};
  assign busDout  = wideReg ? wdataReg
                            : {8'h00, ctl.lane ? wdataReg[15:8] : wdataReg[7:0]};
  assign busDoe   = ctl.driveData;

  always_comb begin
    busCsN = '1;
    if (ctl.driveCs) busCsN[csIdxReg] = 1'b0;
  end

  assign busRdN   = !(ctl.rdStrobe && !selReg);
  assign busWrLoN = !(ctl.wrStrobe && !selReg && laneMask[0]);
  assign busWrHiN = !(ctl.wrStrobe && !selReg && laneMask[1]);
  assign busOeN   = !(ctl.rdStrobe && selReg);
  assign busWeN   = !(ctl.wrStrobe && selReg);
  assign busLbN   = !(anyStb && selReg && laneMask[0]);
  assign busUbN   = !(anyStb && selReg && laneMask[1]);
  assign rdata    = rdataReg;
endmodule

// File: rtl/ebc_top.sv
module ebc_top
  import ebc_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int ADDR_W = 24
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [CFG_W*NUM_CS-1:0] cfgFlat,
  input  logic                    reqValid,
  input  logic                    reqWrite,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [15:0]             reqWdata,
  input  logic [1:0]              reqBe,
  output logic                    reqReady,
  output logic                    reqErr,
  output logic [15:0]             reqRdata,
  output logic [ADDR_W-1:0]       busAddr,
  output logic [15:0]             busDout,
  output logic                    busDoe,
  input  logic [15:0]             busDin,
  output logic [NUM_CS-1:0]       busCsN,
  output logic                    busRdN,
  output logic                    busWrLoN,
  output logic                    busWrHiN,
  output logic                    busWeN,
  output logic                    busOeN,
  output logic                    busUbN,
  output logic                    busLbN,
  input  logic                    busWaitN
);
  localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

  busCtl_t          ctl;
  logic             hit, cfgWide, cfgSel, cfgEarly;
  logic [IDX_W-1:0] hitIdx;
  logic [2:0]       cfgWs;

  ebc_decode #(.NUM_CS(NUM_CS), .IDX_W(IDX_W)) i_decode (
    .cfgFlat(cfgFlat), .addrTop(reqAddr[ADDR_W-1 -: 8]), .hit(hit), .hitIdx(hitIdx),
    .cfgWide(cfgWide), .cfgSel(cfgSel), .cfgEarly(cfgEarly), .cfgWs(cfgWs));

  ebc_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqBe(reqBe),
    .hit(hit), .cfgWide(cfgWide), .cfgEarly(cfgEarly), .cfgWs(cfgWs),
    .busWaitN(busWaitN), .ctl(ctl), .reqReady(reqReady), .reqErr(reqErr));

  ebc_datapath #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddrHi(reqAddr[ADDR_W-1:1]),
    .reqWdata(reqWdata), .reqBe(reqBe), .hitIdx(hitIdx), .cfgWide(cfgWide),
    .cfgSel(cfgSel), .busDin(busDin), .busAddr(busAddr), .busDout(busDout),
    .busDoe(busDoe), .busCsN(busCsN), .busRdN(busRdN), .busWrLoN(busWrLoN),
    .busWrHiN(busWrHiN), .busWeN(busWeN), .busOeN(busOeN), .busUbN(busUbN),
    .busLbN(busLbN), .rdata(reqRdata));
endmodule

// File: rtl/ebc_checker.sv
module ebc_checker #(
  parameter int NUM_CS = 8,
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CS-1:0] busCsN,
  input logic              busRdN,
  input logic              busWrLoN,
  input logic              busWrHiN,
  input logic              busWeN,
  input logic              busOeN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [15:0]       busDout,
  input logic              busDoe,
  input logic              reqReady,
  input logic              reqErr
);
  logic wrAct, anyAct;
  assign wrAct  = !busWrLoN || !busWrHiN || !busWeN;
  assign anyAct = wrAct || !busRdN || !busOeN;

  p_single_cs_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~busCsN));

  p_err_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqErr) |-> (&busCsN && !anyAct));

  p_strobe_needs_cs_r3: assert property (@(posedge clk) disable iff (!rstN)
    anyAct |-> !(&busCsN));

  p_style_exclusive_r4: assert property (@(posedge clk) disable iff (!rstN)
    !((!busWrLoN || !busWrHiN || !busRdN) && (!busWeN || !busOeN)));

  p_write_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrAct && $past(wrAct)) |-> ($stable(busAddr) && $stable(busDout)));

  p_no_contention_r10: assert property (@(posedge clk) disable iff (!rstN)
    busDoe |-> (busRdN && busOeN));

  p_ready_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |=> !reqReady);
endmodule

bind ebc_top ebc_checker #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) i_ebc_checker (
  .clk(clk), .rstN(rstN), .busCsN(busCsN), .busRdN(busRdN), .busWrLoN(busWrLoN),
  .busWrHiN(busWrHiN), .busWeN(busWeN), .busOeN(busOeN), .busAddr(busAddr),
  .busDout(busDout), .busDoe(busDoe), .reqReady(reqReady), .reqErr(reqErr));

// File: tb/test_ebc_top.sv
module test_ebc_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [143:0] cfgFlat = '0;
  logic         reqValid = 1'b0, reqWrite = 1'b0;
  logic [23:0]  reqAddr = '0;
  logic [15:0]  reqWdata = '0;
  logic [1:0]   reqBe = 2'b11;
  logic         reqReady, reqErr;
  logic [15:0]  reqRdata, busDout, busDin;
  logic [23:0]  busAddr;
  logic         busDoe, busRdN, busWrLoN, busWrHiN, busWeN, busOeN, busUbN, busLbN;
  logic [7:0]   busCsN;
  logic         busWaitN = 1'b1;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  ebc_top i_ebc_top (
    .clk(clk), .rstN(rstN), .cfgFlat(cfgFlat), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe), .reqReady(reqReady),
    .reqErr(reqErr), .reqRdata(reqRdata), .busAddr(busAddr), .busDout(busDout),
    .busDoe(busDoe), .busDin(busDin), .busCsN(busCsN), .busRdN(busRdN),
    .busWrLoN(busWrLoN), .busWrHiN(busWrHiN), .busWeN(busWeN), .busOeN(busOeN),
    .busUbN(busUbN), .busLbN(busLbN), .busWaitN(busWaitN));

  // memory model: each lane returns a function of the address
  assign busDin = {busAddr[7:0] ^ 8'hA5, busAddr[7:0] ^ 8'h5A};

  function automatic logic [17:0] mkCfg(input logic early, sel, input int ws,
                                        input logic wide, input int sizeLog,
                                        input logic [7:0] base, input logic en);
    return {early, sel, 3'(ws), wide, 3'(sizeLog), base, en};
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic runReq(input logic wr, input logic [23:0] addr, input logic [15:0] wd,
                        input logic [1:0] be, input int k, input int expCs,
                        input logic eWide, eSel, eEarly, input int eWs);
    int n = 0, csCyc = 0, stbCyc = 0, waitUsed = 0, badCs = 0, badLane = 0;
    int nb, core0, core, hold, extra, expCsCyc, expStb, expLat;
    logic gotCs = 1'b0, earlyObs = 1'b0, gotStb = 1'b0, stb, lo, hi, eLo, eHi;
    logic firstLane, lastLane, errSeen;
    logic [23:0] firstA = '0, lastA = '0;
    logic [15:0] expRd, rd;
    logic [7:0] a0;
    @(negedge clk);
    reqWrite = wr; reqAddr = addr; reqWdata = wd; reqBe = be; reqValid = 1'b1;
    busWaitN = 1'b1;
    forever begin
      @(negedge clk);
      n++;
      stb = eSel ? (!busOeN || !busWeN) : (!busRdN || !busWrLoN || !busWrHiN);
      if (busCsN != 8'hFF) begin
        csCyc++;
        if (expCs < 0 || busCsN != ~(8'd1 << expCs)) badCs++;
        if (!gotCs) begin gotCs = 1'b1; earlyObs = stb; end
      end
      if (eSel && !(busRdN && busWrLoN && busWrHiN)) badLane++;
      if (!eSel && !(busWeN && busOeN && busUbN && busLbN)) badLane++;
      if (stb) begin
        stbCyc++;
        if (!gotStb) begin gotStb = 1'b1; firstA = busAddr; end
        lastA = busAddr;
        lo = eSel ? !busLbN : !busWrLoN;
        hi = eSel ? !busUbN : !busWrHiN;
        eLo = eWide ? be[0] : 1'b1;
        eHi = eWide ? be[1] : 1'b0;
        if (wr) begin
          if (lo != eLo || hi != eHi || !busDoe) badLane++;
          if (busDout != (eWide ? wd : {8'h00, busAddr[0] ? wd[15:8] : wd[7:0]})) badLane++;
        end else begin
          if (busDoe) badLane++;
          if (eSel && (lo != eLo || hi != eHi)) badLane++;
        end
      end
      if (stb && waitUsed < k) begin busWaitN = 1'b0; waitUsed++; end
      else busWaitN = 1'b1;
      if (reqReady || n > 200) break;
    end
    errSeen = reqErr; rd = reqRdata;
    reqValid = 1'b0; busWaitN = 1'b1;

    if (expCs < 0) begin
      check(n == 1 && errSeen, "R2 error latency", n, 1);
      check(csCyc == 0 && stbCyc == 0, "R2 no bus activity", csCyc + stbCyc, 0);
      return;
    end
    nb        = eWide ? 1 : ((be == 2'b11) ? 2 : 1);
    firstLane = eWide ? 1'b0 : !be[0];
    lastLane  = eWide ? 1'b0 : be[1];
    core0     = (1 + eWs > k + 1) ? 1 + eWs : k + 1;
    core      = 1 + eWs;
    hold      = (wr && eWs > 0) ? 1 : 0;
    extra     = (!wr && eEarly) ? 1 : 0;
    expCsCyc  = (1 + core0 + hold) + (nb - 1) * (1 + core + hold);
    expStb    = core0 + extra + (nb - 1) * (core + extra);
    expLat    = expCsCyc + 1;
    check(n == expLat && !errSeen, "R11 latency", n, expLat);
    check(badCs == 0 && csCyc > 0, "R1 select", badCs, 0);
    check(csCyc == expCsCyc, "R7 select cycles", csCyc, expCsCyc);
    check(stbCyc == expStb, k > 0 ? "R6 wait extension" : "R5 strobe length", stbCyc, expStb);
    check(badLane == 0, eSel ? "R4 byte-select lanes" : "R3 byte-write lanes", badLane, 0);
    check(firstA == {addr[23:1], firstLane} && lastA == {addr[23:1], lastLane},
          "R9 byte order", int'(firstA[0]) * 2 + int'(lastA[0]),
          int'(firstLane) * 2 + int'(lastLane));
    if (!wr) begin
      check(earlyObs == eEarly, "R8 read start", int'(earlyObs), int'(eEarly));
      a0 = {addr[7:1], 1'b0};
      if (eWide) expRd = {a0 ^ 8'hA5, a0 ^ 8'h5A};
      else expRd = {be[1] ? ((a0 | 8'h01) ^ 8'h5A) : 8'h00, be[0] ? (a0 ^ 8'h5A) : 8'h00};
      check(rd == expRd, "R10 read data", int'(rd), int'(expRd));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int txn = 0;
    int ws;
    cfgFlat[0*18 +: 18] = mkCfg(1'b0, 1'b0, 0, 1'b1, 0, 8'h00, 1'b1);
    cfgFlat[2*18 +: 18] = mkCfg(1'b0, 1'b1, 2, 1'b1, 0, 8'h10, 1'b1);
    cfgFlat[3*18 +: 18] = mkCfg(1'b0, 1'b0, 1, 1'b0, 2, 8'h40, 1'b1);
    repeat (3) @(negedge clk);
    // R12: idle after reset
    check(busCsN == 8'hFF && busRdN && busWrLoN && busWrHiN && busWeN && busOeN &&
          busUbN && busLbN && !busDoe && !reqReady, "R12 reset idle", int'(busCsN), 255);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int wr = 0; wr < 2; wr++)
      for (int wide = 0; wide < 2; wide++)
        for (int sel = 0; sel < 2; sel++)
          for (int wsi = 0; wsi < 3; wsi++)
            for (int be = 1; be < 4; be++)
              for (int early = 0; early < (wr == 1 ? 1 : 2); early++) begin
                ws = (wsi == 2) ? 3 : wsi;
                cfgFlat[1*18 +: 18] = mkCfg(early[0], sel[0], ws, wide[0], 4, 8'h10, 1'b1);
                txn++;
                runReq(wr[0], 24'h123400 | 24'((txn * 6) & 8'hFE), 16'(txn * 16'h1357 + 16'h2468),
                       be[1:0], 0, 1, wide[0], sel[0], early[0], ws);
              end

    // R6: wait input stretches the strobe beyond the programmed count
    for (int wr = 0; wr < 2; wr++)
      for (int ws2 = 0; ws2 < 2; ws2++)
        for (int k = 2; k < 6; k += 3) begin
          cfgFlat[1*18 +: 18] = mkCfg(1'b0, 1'b0, ws2, 1'b1, 4, 8'h10, 1'b1);
          runReq(wr[0], 24'h1A0010, 16'hBEEF, 2'b11, k, 1, 1'b1, 1'b0, 1'b0, ws2);
        end

    cfgFlat[1*18 +: 18] = mkCfg(1'b0, 1'b0, 0, 1'b1, 4, 8'h10, 1'b1);
    // R1: overlap resolved to region 1, plain hits to regions 0 and 3
    runReq(1'b0, 24'h100020, 16'h0, 2'b11, 0, 1, 1'b1, 1'b0, 1'b0, 0);
    runReq(1'b1, 24'h00ABCE, 16'hCAFE, 2'b11, 0, 0, 1'b1, 1'b0, 1'b0, 0);
    runReq(1'b0, 24'h430042, 16'h0, 2'b11, 0, 3, 1'b0, 1'b0, 1'b0, 1);
    // R2: unmapped address
    runReq(1'b1, 24'h800000, 16'h1111, 2'b11, 0, -1, 1'b1, 1'b0, 1'b0, 0);
    runReq(1'b0, 24'hF00000, 16'h0, 2'b01, 0, -1, 1'b1, 1'b0, 1'b0, 0);
    // after the error the next mapped access still works
    runReq(1'b0, 24'h00FF00, 16'h0, 2'b11, 0, 0, 1'b1, 1'b0, 1'b0, 0);

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule